// File: doc/BRIEF.md
# Serial Receive Byte Deserializer

This block sits between an Ethernet line interface and the system logic. The line interface delivers received frames as one bit per rising edge of its own recovered receive clock, nominally 10 MHz, together with a flag that is high while a frame is being decoded. The block collects those bits into bytes in the receive-clock domain. It then passes each finished byte into an unrelated system clock domain, where the byte appears on an 8-bit bus with a valid strobe that lasts one system cycle. At 10 Mbit/s this gives 1.25 MHz of bytes.

Every bit of the frame is forwarded: preamble, start delimiter, header, payload and whatever trailer bits reach a byte boundary. The block does not search for a delimiter and does not realign. Byte boundaries count from the first receive-clock edge after the active flag rises. The assembly logic is held cleared whenever the active flag is low or the system reset is asserted, so a frame that ends part-way through a byte leaves nothing behind for the next frame. The receive clock stops when a frame ends. Bits that have not yet completed a byte at that point are lost, and this is intended.

Top module: `rx_byte_deserializer`

## Requirements
- R1: The serial input is sampled on each rising edge of `rx_clk` while `rx_active` is high. The first bit sampled for a byte lands in bit 0 of `byte_out` and the eighth lands in bit 7.
- R2: Each group of eight consecutive sampled bits produces exactly one `byte_valid` pulse carrying that byte. A frame of N whole bytes produces exactly N pulses, in arrival order.
- R3: `byte_valid` is never high on two consecutive `sys_clk` rising edges.
- R4: `byte_out` changes only on a cycle in which `byte_valid` is high. It holds its value until the next pulse.
- R5: While `sys_rst_n` is low for two or more consecutive `sys_clk` edges, `byte_valid` is 0 and `byte_out` is 8'h00 from the following edge on.
- R6: When `rx_active` goes low, the bit count and any partial byte are discarded without a pulse. The first bit of the next frame starts a new byte at bit 0.
- R7: Byte values pass through unaltered whatever the bit pattern, including alternating preamble bytes (8'h55), the delimiter value 8'hD5, 8'h00 and 8'hFF.
- R8: No `byte_valid` pulse occurs unless a byte was completed in the receive domain. This holds while `rx_active` stays low and after a system reset.
- R9: The pulse for a byte appears within 5 `sys_clk` cycles of the receive-clock edge that completed it, even if `rx_clk` stops right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock, asynchronous to `rx_clk` |
| sys_rst_n | input | 1 | Active-low system reset |
| rx_clk | input | 1 | Recovered receive clock, stops between frames |
| rx_active | input | 1 | High while a frame is being received |
| rx_bit | input | 1 | Serial receive data, sampled on `rx_clk` rising edge |
| byte_out | output | 8 | Most recently delivered byte, in the `sys_clk` domain |
| byte_valid | output | 1 | One-cycle strobe marking a new `byte_out` |

## Verification
The assertions check four rules on every cycle. The strobe never lasts two cycles. The output byte moves only together with the strobe. Outputs are cleared under a held system reset. The crossing flag flips only when the bit counter wraps past its last position. Bit ordering, the number of pulses per frame, the discarding of a partial byte across a drop of `rx_active`, the crossing latency once the receive clock stops, and value transparency for preamble and delimiter patterns can only be shown by the bench. Its scoreboard predicts every byte from the bits it drives and flags any missing, extra or late strobe.

// File: rtl/rxd_pkg.sv
// Shared defaults for the serial receive deserializer.
// Assumes: nothing; holds constants only.
package rxd_pkg;
    parameter int RXD_BYTE_W_DEF   = 8;  // bits per delivered word
    parameter int RXD_SYNC_DEPTH   = 2;  // flip-flops in the flag synchronizer
endpackage

// File: rtl/rxd_bit_packer.sv
// Receive-domain byte assembler.
// Shifts serial bits in LSB first. On every BYTE_W-th bit it copies the
// finished word into a holding register and flips a crossing flag.
// Assumes: clr_n drops asynchronously whenever a frame ends, because
// rx_clk may stop at that point. The flag and holding register clear only
// on the system reset, so the flag parity the other domain has already
// seen is kept across frames.
module rxd_bit_packer #(
    parameter int BYTE_W = rxd_pkg::RXD_BYTE_W_DEF
) (
    input  logic              rx_clk,
    input  logic              clr_n,      // frame-scope clear (active low)
    input  logic              sys_rst_n,  // system reset (active low)
    input  logic              rx_bit,
    output logic [BYTE_W-1:0] hold_word,
    output logic              xfer_flag,
    output logic [$clog2(BYTE_W)-1:0] bit_pos
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] next_word;

    // Next shift value: the new bit enters at the top and older bits move toward bit 0.
    assign next_word = {rx_bit, shift_q[BYTE_W-1:1]};

    // Bit counter and shift register, cleared between frames.
    always_ff @(posedge rx_clk or negedge clr_n) begin
        if (!clr_n) begin
            bit_pos <= '0;
            shift_q <= '0;
        end else begin
            shift_q <= next_word;
            bit_pos <= (bit_pos == LAST_POS) ? '0 : bit_pos + 1'b1;
        end
    end

    // Holding register and crossing flag, updated once per finished word.
    always_ff @(posedge rx_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            hold_word <= '0;
            xfer_flag <= 1'b0;
        end else if (clr_n && bit_pos == LAST_POS) begin
            hold_word <= next_word;
            xfer_flag <= ~xfer_flag;
        end
    end
endmodule

// File: rtl/rxd_flag_sync.sv
// Multi-flop synchronizer for a single-bit level.
// Assumes: the input changes far less often than once per STAGES clocks.
module rxd_flag_sync #(
    parameter int STAGES = rxd_pkg::RXD_SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // One-stage capture, synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            // Shift chain, synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rxd_sys_handoff.sv
// System-domain side of the byte crossing.
// Detects a change of the synchronized flag, captures the holding register
// into the output and raises a one-cycle strobe.
// Assumes: the holding register has been stable for at least the
// synchronizer depth when the flag change is seen.
module rxd_sys_handoff #(
    parameter int BYTE_W = rxd_pkg::RXD_BYTE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_sync,
    input  logic [BYTE_W-1:0] hold_word,
    output logic [BYTE_W-1:0] word_out,
    output logic              word_valid
);
    logic flag_seen_q;
    logic flag_edge;

    assign flag_edge = flag_sync ^ flag_seen_q;

    // Edge detection, output capture and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_seen_q <= 1'b0;
            word_out    <= '0;
            word_valid  <= 1'b0;
        end else begin
            flag_seen_q <= flag_sync;
            word_valid  <= flag_edge;
            if (flag_edge) word_out <= hold_word;
        end
    end
endmodule

// File: rtl/rx_byte_deserializer.sv
// Serial receive deserializer: packs a serial frame into bytes on the
// recovered receive clock and delivers each byte to the system clock
// domain with a one-cycle strobe.
// Assumes: rx_clk and sys_clk are unrelated. rx_active rises before the
// first receive edge of a frame. sys_clk is faster than the byte rate
// by a wide margin.
module rx_byte_deserializer #(
    parameter int BYTE_W      = rxd_pkg::RXD_BYTE_W_DEF,
    parameter int SYNC_STAGES = rxd_pkg::RXD_SYNC_DEPTH
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              rx_clk,
    input  logic              rx_active,
    input  logic              rx_bit,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_valid
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              frame_clr_n;
    logic              sys_rst_q;
    logic [BYTE_W-1:0] hold_word;
    logic              xfer_flag;
    logic              flag_sync;
    logic [CNT_W-1:0]  bit_pos;

    // Frame-scope clear: inactive line or system reset.
    assign frame_clr_n = sys_rst_n & rx_active;

    // Retime the system reset for use as a synchronous reset in this domain.
    always_ff @(posedge sys_clk) begin
        sys_rst_q <= sys_rst_n;
    end

    rxd_bit_packer #(.BYTE_W(BYTE_W)) u_packer (
        .rx_clk    (rx_clk),
        .clr_n     (frame_clr_n),
        .sys_rst_n (sys_rst_n),
        .rx_bit    (rx_bit),
        .hold_word (hold_word),
        .xfer_flag (xfer_flag),
        .bit_pos   (bit_pos)
    );

    rxd_flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (sys_clk),
        .rst_n (sys_rst_q),
        .d     (xfer_flag),
        .q     (flag_sync)
    );

    rxd_sys_handoff #(.BYTE_W(BYTE_W)) u_handoff (
        .clk        (sys_clk),
        .rst_n      (sys_rst_q),
        .flag_sync  (flag_sync),
        .hold_word  (hold_word),
        .word_out   (byte_out),
        .word_valid (byte_valid)
    );
endmodule

// File: rtl/rx_byte_deserializer_chk.sv
// Property checker for the serial receive deserializer, bound to the top.
module rx_byte_deserializer_chk #(
    parameter int BYTE_W = rxd_pkg::RXD_BYTE_W_DEF,
    parameter int CNT_W  = $clog2(BYTE_W)
) (
    input logic              sys_clk,
    input logic              sys_rst_n,
    input logic              rx_clk,
    input logic              rx_active,
    input logic [BYTE_W-1:0] byte_out,
    input logic              byte_valid,
    input logic              xfer_flag,
    input logic [CNT_W-1:0]  bit_pos
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(BYTE_W - 1);

    // R3: strobe lasts one cycle
    a_r3_single_pulse: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        byte_valid |=> !byte_valid);

    // R4: output word moves only with the strobe
    a_r4_word_stable: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !byte_valid |-> $stable(byte_out));

    // R5: held reset clears outputs
    a_r5_reset_clear: assert property (@(posedge sys_clk)
        (!sys_rst_n ##1 !sys_rst_n) |=> (!byte_valid && byte_out == '0));

    // R2: crossing flag flips only on the counter wrap
    a_r2_flag_on_wrap: assert property (@(posedge rx_clk) disable iff (!sys_rst_n || !rx_active)
        !$stable(xfer_flag) |-> $past(bit_pos) == LAST_POS);
endmodule

bind rx_byte_deserializer rx_byte_deserializer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .sys_clk    (sys_clk),
    .sys_rst_n  (sys_rst_n),
    .rx_clk     (rx_clk),
    .rx_active  (rx_active),
    .byte_out   (byte_out),
    .byte_valid (byte_valid),
    .xfer_flag  (xfer_flag),
    .bit_pos    (bit_pos)
);

// File: tb/rx_byte_deserializer_test.sv
// Scoreboard bench: the driver predicts bytes from the bits it sends; the
// monitor compares every strobe against the queue.
module rx_byte_deserializer_test;
    logic       sys_clk = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       rx_clk = 1'b0;
    logic       rx_active = 1'b0;
    logic       rx_bit = 1'b0;
    logic [7:0] byte_out;
    logic       byte_valid;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_q[$];
    logic [7:0] last_out = 8'h00;
    logic       last_valid = 1'b0;
    int         since_edge = 0;

    rx_byte_deserializer uut (
        .sys_clk    (sys_clk),
        .sys_rst_n  (sys_rst_n),
        .rx_clk     (rx_clk),
        .rx_active  (rx_active),
        .rx_bit     (rx_bit),
        .byte_out   (byte_out),
        .byte_valid (byte_valid)
    );

    always #5 sys_clk = ~sys_clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One serial bit: set data while rx_clk is low, then raise it.
    task automatic send_bit(input logic b);
        rx_bit = b;
        #47;
        rx_clk = 1'b1;
        since_edge = 0;
        #50;
        rx_clk = 1'b0;
    endtask

    // One byte LSB first (R1); predicted word pushed at its final edge.
    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            rx_bit = v[i];
            #47;
            rx_clk = 1'b1;
            since_edge = 0;
            if (i == 7) exp_q.push_back(v);
            #50;
            rx_clk = 1'b0;
        end
    endtask

    task automatic end_frame();
        #30;
        rx_active = 1'b0;
        repeat (8) @(posedge sys_clk);
        #1;
        // R9: every pulse has arrived within the window after the last edge
        check(exp_q.size() == 0, "R9", exp_q.size(), 0);
    endtask

    // Scoreboard monitor, sampling at the falling sys_clk edge.
    always @(negedge sys_clk) begin
        if (sys_rst_n) since_edge++;
        if (byte_valid) begin
            // R3
            check(!last_valid, "R3", 1, 0);
            if (exp_q.size() == 0) begin
                // R8: strobe without a completed byte
                check(1'b0, "R8", byte_out, -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                // R2/R7: value and order
                check(byte_out == e, "R2", byte_out, e);
                // R9: latency bound
                check(since_edge <= 5, "R9", since_edge, 5);
            end
        end else if (sys_rst_n) begin
            // R4
            check(byte_out == last_out, "R4", byte_out, last_out);
        end
        last_out   = byte_out;
        last_valid = byte_valid;
    end

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge sys_clk);
        #2;
        // R5: reset state
        check(byte_valid == 1'b0, "R5", byte_valid, 0);
        check(byte_out == 8'h00, "R5", byte_out, 0);
        sys_rst_n = 1'b1;
        repeat (4) @(posedge sys_clk);

        // R7 and R1: preamble, delimiter and edge patterns
        #13;
        rx_active = 1'b1;
        #20;
        for (int k = 0; k < 7; k++) send_byte(8'h55);
        send_byte(8'hD5);
        send_byte(8'h00);
        send_byte(8'hFF);
        send_byte(8'h01);   // R1: first bit lands in bit 0
        send_byte(8'h80);
        send_byte(8'h3C);
        end_frame();
        check(byte_out == 8'h3C, "R4", byte_out, 8'h3C);

        // R6: partial byte dropped when the frame ends
        rx_active = 1'b1;
        #20;
        send_byte(8'hA7);
        for (int k = 0; k < 5; k++) send_bit(1'b1);
        end_frame();
        // R8: idle line, no pulses
        repeat (40) @(posedge sys_clk);
        #1;
        check(byte_out == 8'hA7, "R8", byte_out, 8'hA7);

        // R6: next frame realigns to its first bit
        rx_active = 1'b1;
        #20;
        send_byte(8'h12);
        send_byte(8'hC4);
        end_frame();
        check(byte_out == 8'hC4, "R6", byte_out, 8'hC4);

        // R5: reset mid-run clears outputs
        @(negedge sys_clk);
        sys_rst_n = 1'b0;
        repeat (3) @(posedge sys_clk);
        #2;
        check(byte_valid == 1'b0, "R5", byte_valid, 0);
        check(byte_out == 8'h00, "R5", byte_out, 0);
        @(negedge sys_clk);
        sys_rst_n = 1'b1;
        repeat (10) @(posedge sys_clk);
        #1;
        // R8: no pulse after reset release
        check(byte_out == 8'h00, "R8", byte_out, 0);

        // R2: frame after reset, back-to-back bytes
        rx_active = 1'b1;
        #20;
        send_byte(8'h5A);
        send_byte(8'h96);
        send_byte(8'hE1);
        end_frame();
        check(byte_out == 8'hE1, "R2", byte_out, 8'hE1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule